// File: doc/BRIEF.md
# Asynchronous byte-wide SRAM access controller

This block sits between a synchronous host and an asynchronous static RAM of 2048 bytes. It moves one byte per request. The host raises a request with a read/write select, an 11-bit address and, for writes, a data byte. The controller then drives the memory's address lines, its three active-low strobes (chip enable, write enable and output enable) and its shared 8-bit data bus. When the access is complete it pulses a ready flag for one cycle. On a read, the captured byte appears on the read-data output in that same cycle.

Every timing limit of the memory is held in nanoseconds. The limits are chosen by a speed-grade parameter (100, 120, 150 or 200 ns). Each limit is turned into a clock-cycle count from a clock-period parameter, using the rule cyc(t) = ceil(t / T_clk) + 1. The extra cycle is margin for skew on the board.

During a write, chip enable falls first and write enable falls after it, so the write begins on the later fall. Both strobes rise on the same edge, so the write ends on the earlier rise. Output enable stays high for the whole write. The controller drives the data bus only while both strobes are low, and for a short hold window after they rise. A recovery timer keeps write enable high for a minimum gap before the next access can begin.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held, chip enable, write enable and output enable are all high (inactive), ready is low and the read-data output is zero.
- R2: For a read accepted at clock edge k, chip enable and output enable are low and write enable is high from edge k until edge k+A, where A = max(cyc(t_access), cyc(t_oe_access)). With the default settings (10 ns clock, 100 ns grade) A is 11.
- R3: The read-data output takes the bus value present in the last cycle of the read window. It keeps that value until the next read completes.
- R4: For a write accepted at edge k, chip enable falls at edge k. Write enable falls at edge k+S, where S = cyc(t_addr_setup). Both rise together at edge k+S+P, where P = max(cyc(t_write_pulse), cyc(t_data_setup)+1). With the defaults S is 1 and P is 9.
- R5: Output enable stays high in every cycle that belongs to a write, and in every cycle where write enable is low.
- R6: During a write, the controller drives the write byte onto the bus from edge k+S+1 until edge k+S+P+H, where H = max(1, ceil(t_data_hold / T_clk)). It never drives the bus while output enable is low.
- R7: The address lines take the request address at the accept edge. They do not change again until the next request is accepted.
- R8: Ready is high for exactly one cycle per request. For a read, that cycle starts at edge k+A. For a write, it starts at edge k+S+P+H.
- R9: A request is accepted only while the controller is idle. After a write, it is also held off until the recovery count R = cyc(t_write_recovery) has run out, so the earliest accept edge is the (R+1)-th edge after the edge that raised write enable. A request held high while an access is in progress starts nothing. With the defaults R is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request; held high until ready is seen |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Byte address of the request |
| req_wdata | input | 8 | Byte to write |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| sram_addr | output | 11 | Memory address lines |
| sram_dq | inout | 8 | Shared memory data bus |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |

## Verification
All results are counted from the rising edge at which the controller samples the request.

- A read has its strobes low for the 11 cycles after that edge. Ready and the captured byte arrive at the 11th edge.
- A write drops write enable one edge after chip enable, and drives data from the second cycle that write enable is low. It releases both strobes 9 edges later, holds data for one more cycle, and gives ready at the 11th edge. The next accept is no earlier than the third edge after write enable rose.

The bench model advances one step on each rising edge, building the expected pin values from these counts. The comparison happens on the following falling edge, so every registered output has settled before it is sampled. A memory model in the bench returns a poison byte until the access time has passed, so a read captured too early gets a wrong value.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WSETUP,
      ST_WPULSE,
      ST_WHOLD
   } ctl_state_e;

   typedef enum logic [2:0] {
      LIM_ACCESS,
      LIM_OE_ACCESS,
      LIM_WPULSE,
      LIM_DSETUP,
      LIM_DHOLD,
      LIM_RECOVER,
      LIM_ASETUP
   } limit_e;

   function automatic int cdiv(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // ceiling of the limit in cycles plus one cycle of skew margin
   function automatic int phase_cycles(input int ns, input int clk_ns);
      return cdiv(ns, clk_ns) + 1;
   endfunction

   function automatic bit grade_ok(input int grade);
      return (grade == 100) || (grade == 120) || (grade == 150) || (grade == 200);
   endfunction

   // nanosecond limit of one speed grade
   function automatic int grade_limit(input int grade, input limit_e lim);
      case (lim)
         LIM_ACCESS:    return grade;
         LIM_OE_ACCESS: return (grade == 120) ? 60 : (grade == 150) ? 70 :
                               (grade == 200) ? 100 : 50;
         LIM_WPULSE:    return (grade == 120) ? 90 : (grade == 150) ? 100 :
                               (grade == 200) ? 150 : 75;
         LIM_DSETUP:    return (grade == 120) ? 50 : (grade == 150) ? 60 :
                               (grade == 200) ? 50 : 40;
         LIM_DHOLD:     return 10;
         LIM_RECOVER:   return 10;
         default:       return 0;
      endcase
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
   parameter int DW = 8
) (
   inout  wire  [DW-1:0] pad,
   input  logic          drive,
   input  logic [DW-1:0] dout,
   output logic [DW-1:0] din
);

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign pad[i] = drive ? dout[i] : 1'bz;
   end

   assign din = pad;

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
   import sram_ctl_pkg::*;
#(
   parameter int AW       = 11,
   parameter int DW       = 8,
   parameter int CLK_NS   = 10,
   parameter int GRADE_NS = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_ready,
   output logic [DW-1:0] rsp_rdata,
   output logic [AW-1:0] sram_addr,
   inout  wire  [DW-1:0] sram_dq,
   output logic          sram_ce_n,
   output logic          sram_we_n,
   output logic          sram_oe_n
);

   localparam int RD_CYC  = imax(phase_cycles(grade_limit(GRADE_NS, LIM_ACCESS), CLK_NS),
                                 phase_cycles(grade_limit(GRADE_NS, LIM_OE_ACCESS), CLK_NS));
   localparam int SET_CYC = phase_cycles(grade_limit(GRADE_NS, LIM_ASETUP), CLK_NS);
   localparam int PUL_CYC = imax(phase_cycles(grade_limit(GRADE_NS, LIM_WPULSE), CLK_NS),
                                 phase_cycles(grade_limit(GRADE_NS, LIM_DSETUP), CLK_NS) + 1);
   localparam int HLD_CYC = imax(1, cdiv(grade_limit(GRADE_NS, LIM_DHOLD), CLK_NS));
   localparam int REC_CYC = phase_cycles(grade_limit(GRADE_NS, LIM_RECOVER), CLK_NS);
   localparam int MAX_CYC = imax(imax(RD_CYC, PUL_CYC), imax(SET_CYC, imax(HLD_CYC, REC_CYC)));
   localparam int CW      = $clog2(MAX_CYC + 1);

   if (!grade_ok(GRADE_NS)) begin : g_bad_grade
      $error("sram_async_ctl: GRADE_NS must be 100, 120, 150 or 200");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_async_ctl: CLK_NS must be positive");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("sram_async_ctl: AW and DW must be positive");
   end

   ctl_state_e    st_q, st_d;
   logic          ph_load, ph_zero, rec_load, rec_zero;
   logic [CW-1:0] ph_val;
   logic          ce_q, ce_d, we_q, we_d, oe_q, oe_d;
   logic          rdy_q, rdy_d, drv_q, drv_d, accept, capture;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdat_q, rdat_q, bus_in;

   sram_phase_timer #(.W(CW)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
   );

   sram_phase_timer #(.W(CW)) u_recover (
      .clk(clk), .rst_n(rst_n), .load(rec_load), .load_val(CW'(REC_CYC)), .zero(rec_zero)
   );

   sram_dq_port #(.DW(DW)) u_dq (
      .pad(sram_dq), .drive(drv_q), .dout(wdat_q), .din(bus_in)
   );

   always_comb begin
      st_d     = st_q;
      ph_load  = 1'b0;
      ph_val   = '0;
      rec_load = 1'b0;
      ce_d     = ce_q;
      we_d     = we_q;
      oe_d     = oe_q;
      rdy_d    = 1'b0;
      accept   = 1'b0;
      capture  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (req_valid && rec_zero) begin
               accept  = 1'b1;
               ce_d    = 1'b0;
               ph_load = 1'b1;
               if (req_write) begin
                  st_d   = ST_WSETUP;
                  ph_val = CW'(SET_CYC - 1);
               end else begin
                  st_d   = ST_READ;
                  oe_d   = 1'b0;
                  ph_val = CW'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (ph_zero) begin
               capture = 1'b1;
               ce_d    = 1'b1;
               oe_d    = 1'b1;
               rdy_d   = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_WSETUP: begin
            if (ph_zero) begin
               we_d    = 1'b0;
               ph_load = 1'b1;
               ph_val  = CW'(PUL_CYC - 1);
               st_d    = ST_WPULSE;
            end
         end
         ST_WPULSE: begin
            if (ph_zero) begin
               we_d     = 1'b1;
               ce_d     = 1'b1;
               rec_load = 1'b1;
               ph_load  = 1'b1;
               ph_val   = CW'(HLD_CYC - 1);
               st_d     = ST_WHOLD;
            end
         end
         ST_WHOLD: begin
            if (ph_zero) begin
               rdy_d = 1'b1;
               st_d  = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // drivers follow both strobes low, and stay on through the hold window
   assign drv_d = (st_q == ST_WPULSE) || ((st_q == ST_WHOLD) && !ph_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ce_q   <= 1'b1;
         we_q   <= 1'b1;
         oe_q   <= 1'b1;
         rdy_q  <= 1'b0;
         drv_q  <= 1'b0;
         addr_q <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
      end else begin
         st_q  <= st_d;
         ce_q  <= ce_d;
         we_q  <= we_d;
         oe_q  <= oe_d;
         rdy_q <= rdy_d;
         drv_q <= drv_d;
         if (accept) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
         end
         if (capture)
            rdat_q <= bus_in;
      end
   end

   assign rsp_ready = rdy_q;
   assign rsp_rdata = rdat_q;
   assign sram_addr = addr_q;
   assign sram_ce_n = ce_q;
   assign sram_we_n = we_q;
   assign sram_oe_n = oe_q;

   assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !sram_ce_n));

   assert_ce_rises_with_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> $rose(sram_ce_n));

   assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);

   assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_q |-> sram_oe_n);

   assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |=> !rsp_ready);

   assert_recovery_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> rec_zero);

endmodule

// File: tb/sram_async_ctl_bench.sv
module sram_async_ctl_bench;

   localparam int CLK_NS = 10;
   localparam int T_ACC = 100, T_OE = 50, T_WP = 75, T_DS = 40, T_DH = 10, T_WR = 10, T_AS = 0;

   function automatic int cyc(input int ns);
      return (ns + CLK_NS - 1) / CLK_NS + 1;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int NA = mx(cyc(T_ACC), cyc(T_OE));
   localparam int NS = cyc(T_AS);
   localparam int NP = mx(cyc(T_WP), cyc(T_DS) + 1);
   localparam int NH = mx(1, (T_DH + CLK_NS - 1) / CLK_NS);
   localparam int NR = cyc(T_WR);
   localparam int ACC_MIN = (T_ACC + CLK_NS - 1) / CLK_NS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [10:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_ready;
   logic [7:0]  rsp_rdata;
   logic [10:0] sram_addr;
   wire  [7:0]  sram_dq;
   logic        sram_ce_n, sram_we_n, sram_oe_n;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS / 2) clk = ~clk;

   sram_async_ctl #(.AW(11), .DW(8), .CLK_NS(CLK_NS), .GRADE_NS(100)) u_sram_async_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_ready(rsp_ready),
      .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_dq(sram_dq),
      .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural memory ----------------
   logic [7:0]  mem [2048];
   int          acc_cnt = 0;
   logic [10:0] acc_addr = '0;
   logic        wact = 1'b0;
   logic [10:0] waddr = '0;
   logic [7:0]  wdat = '0;
   logic        m_drive;
   logic [7:0]  m_q;

   assign m_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
   assign m_q     = (acc_cnt >= ACC_MIN) ? mem[acc_addr] : 8'hA5;
   assign sram_dq = m_drive ? m_q : 8'hzz;

   always @(negedge clk) begin
      if (m_drive)
         acc_cnt = (acc_cnt > 0 && sram_addr == acc_addr) ? acc_cnt + 1 : 1;
      else
         acc_cnt = 0;
      acc_addr = sram_addr;
      if (wact && !(!sram_ce_n && !sram_we_n))
         mem[waddr] = wdat;
      if (!sram_ce_n && !sram_we_n) begin
         waddr = sram_addr;
         wdat  = sram_dq;
      end
      wact = !sram_ce_n && !sram_we_n;
   end

   // ---------------- cycle reference model ----------------
   typedef struct {
      bit ce, we, oe, drv, rdy;
      int kind;   // 0 idle, 1 read, 2 write
      int addr;
      int data;
   } exp_t;

   exp_t        q[$];
   exp_t        cur;
   logic [7:0]  shadow [2048];
   int          edge_n = 0;
   int          free_edge = 0;
   bit          run = 0;
   int          last_rd = 0;

   function automatic exp_t mk(bit ce, bit we, bit oe, bit drv, bit rdy, int kind, int a, int d);
      exp_t e;
      e.ce = ce; e.we = we; e.oe = oe; e.drv = drv; e.rdy = rdy;
      e.kind = kind; e.addr = a; e.data = d;
      return e;
   endfunction

   always @(posedge clk) begin
      edge_n++;
      if (!rst_n) begin
         q.delete();
         cur = mk(1, 1, 1, 0, 0, 0, 0, 0);
         free_edge = 0;
         run = 0;
      end else begin
         run = 1;
         if (q.size() == 0 && req_valid && edge_n >= free_edge) begin
            if (req_write) begin
               for (int i = 0; i < NS; i++) q.push_back(mk(0, 1, 1, 0, 0, 2, req_addr, 0));
               q.push_back(mk(0, 0, 1, 0, 0, 2, req_addr, 0));
               for (int i = 1; i < NP; i++) q.push_back(mk(0, 0, 1, 1, 0, 2, req_addr, req_wdata));
               for (int i = 0; i < NH; i++) q.push_back(mk(1, 1, 1, 1, 0, 2, req_addr, req_wdata));
               q.push_back(mk(1, 1, 1, 0, 1, 2, req_addr, 0));
               shadow[req_addr] = req_wdata;
               free_edge = edge_n + NS + NP + NR + 1;
            end else begin
               for (int i = 0; i < NA; i++) q.push_back(mk(0, 1, 0, 0, 0, 1, req_addr, 0));
               q.push_back(mk(1, 1, 1, 0, 1, 1, req_addr, shadow[req_addr]));
            end
         end
         if (q.size() > 0) cur = q.pop_front();
         else cur = mk(1, 1, 1, 0, 0, 0, 0, 0);
      end
   end

   always @(negedge clk) begin
      if (run) begin
         string st;
         st = (cur.kind == 1) ? "R2" : (cur.kind == 2) ? "R4" : "R9";
         check({sram_ce_n, sram_we_n} == {cur.ce, cur.we}, st,
               {sram_ce_n, sram_we_n}, {cur.ce, cur.we});
         check(sram_oe_n == cur.oe, (cur.kind == 2) ? "R5" : st, sram_oe_n, cur.oe);
         check(rsp_ready == cur.rdy, "R8", rsp_ready, cur.rdy);
         if (cur.drv)
            check(sram_dq == cur.data[7:0], "R6", sram_dq, cur.data);
         if (cur.kind != 0)
            check(sram_addr == cur.addr[10:0], "R7", sram_addr, cur.addr);
         if (cur.rdy && cur.kind == 1)
            last_rd = cur.data;
         check(rsp_rdata == last_rd[7:0], "R3", rsp_rdata, last_rd);
      end
   end

   // ---------------- stimulus ----------------
   task automatic op(input bit wr, input int a, input int d, input bit keep);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a[10:0];
      req_wdata = d[7:0];
      do @(negedge clk); while (!rsp_ready);
      if (!keep) req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lfsr;
      for (int i = 0; i < 2048; i++) begin
         mem[i] = 8'h00;
         shadow[i] = 8'h00;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      check({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1", {sram_ce_n, sram_we_n, sram_oe_n}, 7);
      check(rsp_ready == 1'b0, "R1", rsp_ready, 0);
      check(rsp_rdata == 8'h00, "R1", rsp_rdata, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // single accesses, edges of the address range, overwrite
      op(1, 'h000, 'h11, 0);
      op(1, 'h7FF, 'h5C, 0);
      op(0, 'h000, 0, 0);
      op(0, 'h7FF, 0, 0);
      repeat (3) @(negedge clk);
      op(1, 'h123, 'h3C, 0);
      op(1, 'h123, 'hC3, 0);
      op(0, 'h123, 0, 0);

      // request held high across accesses: R9 recovery gating and busy ignore
      op(1, 'h055, 'h77, 1);
      op(1, 'h056, 'h88, 1);
      op(0, 'h055, 0, 1);
      op(0, 'h056, 0, 1);
      op(1, 'h400, 'h99, 1);
      op(0, 'h400, 0, 0);

      // pseudo-random mix
      lfsr = 'h2B7;
      for (int i = 0; i < 12; i++) begin
         lfsr = ((lfsr << 1) | (((lfsr >> 10) ^ (lfsr >> 8)) & 1)) & 'h7FF;
         op(1, lfsr, (lfsr * 7 + 3) & 'h7F, (i % 3) != 0);
         op(0, lfsr, 0, (i % 2) != 0);
      end
      req_valid = 1'b0;
      repeat (20) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule